// File: doc/BRIEF.md
# Condition Register Field Transfer Unit

This block keeps a 32-bit condition register, split into eight 4-bit fields, and performs register-move operations on it. An opcode selects one operation per cycle. The operations are a masked write of several fields from a 64-bit source, a write of one field picked from a mask, a read of one field picked from a mask, a read of the whole register, and a load of one field from four carry and overflow flags.

Writes land on the rising clock edge when the valid strobe is high. Read results are combinational and reflect the register as it stands in that cycle. The surrounding pipeline supplies the opcode, the 8-bit field mask, the 3-bit field index, the source operand and the flags. It takes the 64-bit result and the current register value. The block is a datapath with no sequencing states. Its only stored state is the register, and each cycle is independent of the previous one.

Top module: `crf_xfer_unit`

## Requirements
- R1: Field n (0..7) of the register, of the source's low word and of the result's low word sits at bits [31-4n : 28-4n], so field 0 is the top nibble of the low word. Mask bit `fld_mask[7-n]` belongs to field n.
- R2: Opcode 1 (masked write) with valid replaces every field whose mask bit is 1 with the same field of `src_data`. Fields whose mask bit is 0 keep their value, and an all-zero mask leaves the register unchanged.
- R3: Opcode 2 (single write) with valid replaces only the lowest-numbered field whose mask bit is 1 with the same field of `src_data`. With an all-zero mask it writes field 7.
- R4: Opcode 3 (single read) puts the lowest-numbered selected field of the register at that field's own position in `result`. Every other bit of `result` is 0, and an all-zero mask gives a zero result.
- R5: Opcode 4 (full read) gives `result` = 32 zero bits followed by the register in bits [31:0].
- R6: Opcode 5 (flag load) with valid writes field `fld_idx` with {`flag_ov`, `flag_ov32`, `flag_ca`, `flag_ca32`}, most significant first. The other fields are unchanged.
- R7: `cr_q` changes only on a rising edge with `op_valid` high. Opcodes 0, 3, 4, 6 and 7 leave it unchanged. A synchronous `rst` clears it to 0 and takes priority over a write.
- R8: `result` is combinational, independent of `op_valid`, and 0 for every opcode other than 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Commits a write opcode on the next edge |
| op_code | input | 3 | Operation select (0..7) |
| fld_mask | input | 8 | Field mask, MSB is field 0 |
| fld_idx | input | 3 | Target field for the flag load |
| src_data | input | 64 | Source operand, low word holds the fields |
| flag_ov | input | 1 | Overflow flag |
| flag_ov32 | input | 1 | 32-bit overflow flag |
| flag_ca | input | 1 | Carry flag |
| flag_ca32 | input | 1 | 32-bit carry flag |
| cr_q | output | 32 | Condition register |
| result | output | 64 | Read result |

## Verification
The hardest cases to reach are the single-field operations with an all-zero mask. These are the default write to field 7 and the zero read result. Uniform random masks produce them only once in 256 draws. The stimulus therefore runs directed cycles with all-zero and multi-hot masks, such as a mask whose lowest selected field is not its highest bit. It then mixes these into a random stream that forces the mask to zero about one cycle in eight. A write presented with valid low and a reset arriving together with a write are also driven on purpose.

// File: rtl/crf_pkg.sv
package crf_pkg;
    localparam int OPW = 3;

    typedef enum logic [OPW-1:0] {
        OP_NOP      = 3'd0,
        OP_WR_MASK  = 3'd1,
        OP_WR_ONE   = 3'd2,
        OP_RD_ONE   = 3'd3,
        OP_RD_ALL   = 3'd4,
        OP_LD_FLAGS = 3'd5,
        OP_RSV6     = 3'd6,
        OP_RSV7     = 3'd7
    } crf_op_e;
endpackage

// File: rtl/crf_prio_pick.sv
module crf_prio_pick #(
    parameter int NF = 8,
    parameter int IW = $clog2(NF)
) (
    input  logic [NF-1:0] mask,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Lowest-numbered field wins; field n is mask bit NF-1-n.
    always_comb begin
        idx = IW'(NF-1);
        any = 1'b0;
        for (int n = NF-1; n >= 0; n--) begin
            if (mask[NF-1-n]) begin
                idx = IW'(n);
                any = 1'b1;
            end
        end
    end

    always_comb begin
        if (any) begin
            assert_pick_is_selected_R3: assert (mask[IW'(NF-1) - idx]);
        end
    end
endmodule

// File: rtl/crf_next_calc.sv
module crf_next_calc
    import crf_pkg::*;
#(
    parameter int NF  = 8,
    parameter int FW  = 4,
    parameter int IW  = $clog2(NF),
    parameter int CRW = NF*FW
) (
    input  logic [CRW-1:0] cr,
    input  crf_op_e        op,
    input  logic [NF-1:0]  mask,
    input  logic [IW-1:0]  pick_idx,
    input  logic [IW-1:0]  fidx,
    input  logic [CRW-1:0] src_lo,
    input  logic [FW-1:0]  flags,
    output logic [CRW-1:0] cr_next
);
    for (genvar g = 0; g < NF; g++) begin : g_fld
        localparam int HI = CRW-1-FW*g;
        always_comb begin
            cr_next[HI -: FW] = cr[HI -: FW];
            unique case (op)
                OP_WR_MASK:  if (mask[NF-1-g]) cr_next[HI -: FW] = src_lo[HI -: FW];
                OP_WR_ONE:   if (pick_idx == IW'(g)) cr_next[HI -: FW] = src_lo[HI -: FW];
                OP_LD_FLAGS: if (fidx == IW'(g)) cr_next[HI -: FW] = flags;
                default:     cr_next[HI -: FW] = cr[HI -: FW];
            endcase
        end
    end
endmodule

// File: rtl/crf_read_fmt.sv
module crf_read_fmt
    import crf_pkg::*;
#(
    parameter int NF  = 8,
    parameter int FW  = 4,
    parameter int IW  = $clog2(NF),
    parameter int CRW = NF*FW,
    parameter int DW  = 64
) (
    input  logic [CRW-1:0] cr,
    input  crf_op_e        op,
    input  logic [IW-1:0]  pick_idx,
    input  logic           pick_any,
    output logic [DW-1:0]  result
);
    logic [CRW-1:0] one_fld;

    for (genvar g = 0; g < NF; g++) begin : g_sel
        localparam int HI = CRW-1-FW*g;
        assign one_fld[HI -: FW] = (pick_any && pick_idx == IW'(g)) ? cr[HI -: FW] : '0;
    end

    always_comb begin
        unique case (op)
            OP_RD_ONE: result = {{(DW-CRW){1'b0}}, one_fld};
            OP_RD_ALL: result = {{(DW-CRW){1'b0}}, cr};
            default:   result = '0;
        endcase
    end
endmodule

// File: rtl/crf_xfer_unit.sv
module crf_xfer_unit
    import crf_pkg::*;
#(
    parameter int NF = 8,
    parameter int FW = 4,
    parameter int DW = 64,
    localparam int IW  = $clog2(NF),
    localparam int CRW = NF*FW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           op_valid,
    input  logic [OPW-1:0] op_code,
    input  logic [NF-1:0]  fld_mask,
    input  logic [IW-1:0]  fld_idx,
    input  logic [DW-1:0]  src_data,
    input  logic           flag_ov,
    input  logic           flag_ov32,
    input  logic           flag_ca,
    input  logic           flag_ca32,
    output logic [CRW-1:0] cr_q,
    output logic [DW-1:0]  result
);
    crf_op_e        op;
    logic [IW-1:0]  pick_idx;
    logic           pick_any;
    logic [CRW-1:0] cr_next;
    logic [FW-1:0]  flags;

    assign op    = crf_op_e'(op_code);
    assign flags = {flag_ov, flag_ov32, flag_ca, flag_ca32};

    crf_prio_pick #(.NF(NF), .IW(IW)) u_pick (
        .mask (fld_mask),
        .idx  (pick_idx),
        .any  (pick_any)
    );

    crf_next_calc #(.NF(NF), .FW(FW), .IW(IW), .CRW(CRW)) u_next (
        .cr       (cr_q),
        .op       (op),
        .mask     (fld_mask),
        .pick_idx (pick_idx),
        .fidx     (fld_idx),
        .src_lo   (src_data[CRW-1:0]),
        .flags    (flags),
        .cr_next  (cr_next)
    );

    crf_read_fmt #(.NF(NF), .FW(FW), .IW(IW), .CRW(CRW), .DW(DW)) u_rd (
        .cr       (cr_q),
        .op       (op),
        .pick_idx (pick_idx),
        .pick_any (pick_any),
        .result   (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cr_q <= '0;
        end else if (op_valid) begin
            cr_q <= cr_next;
        end
    end

    assert_reset_clears_R7: assert property (@(posedge clk) rst |=> cr_q == '0);

    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (!op_valid || op inside {OP_NOP, OP_RD_ONE, OP_RD_ALL, OP_RSV6, OP_RSV7}) |=> $stable(cr_q));

    assert_zero_mask_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_WR_MASK && fld_mask == '0) |=> $stable(cr_q));

    assert_flag_load_R6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_LD_FLAGS) |=>
        (FW'(cr_q >> (FW*(NF-1-int'($past(fld_idx))))) == $past(flags)));

    assert_full_read_R5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RD_ALL) |-> (result == {{(DW-CRW){1'b0}}, cr_q}));

    assert_one_read_R4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RD_ONE) |-> (result[DW-1:CRW] == '0 && (result[CRW-1:0] & ~cr_q) == '0));

    assert_other_result_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !(op inside {OP_RD_ONE, OP_RD_ALL}) |-> result == '0);
endmodule

// File: tb/crf_xfer_unit_tb.sv
module crf_xfer_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [2:0]  op_code;
    logic [7:0]  fld_mask;
    logic [2:0]  fld_idx;
    logic [63:0] src_data;
    logic        flag_ov, flag_ov32, flag_ca, flag_ca32;
    logic [31:0] cr_q;
    logic [63:0] result;

    logic [31:0] cr_ref;
    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crf_xfer_unit u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .fld_mask(fld_mask), .fld_idx(fld_idx), .src_data(src_data),
        .flag_ov(flag_ov), .flag_ov32(flag_ov32), .flag_ca(flag_ca),
        .flag_ca32(flag_ca32), .cr_q(cr_q), .result(result)
    );

    function automatic logic [3:0] get_fld(logic [31:0] v, int n);
        return v[31-4*n -: 4];
    endfunction

    function automatic logic [31:0] put_fld(logic [31:0] v, int n, logic [3:0] d);
        logic [31:0] r = v;
        r[31-4*n -: 4] = d;
        return r;
    endfunction

    function automatic logic [63:0] model_result(logic [2:0] op, logic [7:0] m);
        logic [63:0] r = '0;
        bit done = 0;
        if (op == 3'd4) r = {32'b0, cr_ref};
        if (op == 3'd3) begin
            for (int n = 0; n < 8; n++) begin
                if (!done && m[7-n]) begin
                    r[31-4*n -: 4] = get_fld(cr_ref, n);
                    done = 1;
                end
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] model_next(logic [2:0] op, logic [7:0] m, logic [2:0] fi,
                                               logic [63:0] s, logic [3:0] fl);
        logic [31:0] r = cr_ref;
        int t = 7;
        case (op)
            3'd1: for (int n = 0; n < 8; n++) if (m[7-n]) r = put_fld(r, n, get_fld(s[31:0], n));
            3'd2: begin
                for (int n = 7; n >= 0; n--) if (m[7-n]) t = n;
                r = put_fld(r, t, get_fld(s[31:0], t));
            end
            3'd5: r = put_fld(r, int'(fi), fl);
            default: r = cr_ref;
        endcase
        return r;
    endfunction

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, check result before edge, cr_q after.
    task automatic step(bit r, bit v, logic [2:0] op, logic [7:0] m, logic [2:0] fi,
                        logic [63:0] s, logic [3:0] fl);
        string rtag, ctag;
        logic [63:0] exp_res;
        @(negedge clk);
        rst = r; op_valid = v; op_code = op; fld_mask = m; fld_idx = fi; src_data = s;
        {flag_ov, flag_ov32, flag_ca, flag_ca32} = fl;
        #1;
        exp_res = model_result(op, m);
        rtag = (op == 3'd3) ? "R4 single read" : (op == 3'd4) ? "R5 full read" : "R8 result zero";
        check64(rtag, result, exp_res);
        @(posedge clk);
        if (r) cr_ref = '0;
        else if (v) cr_ref = model_next(op, m, fi, s, fl);
        #1;
        ctag = r ? "R7 reset" : !v ? "R7 no valid" :
               (op == 3'd1) ? "R2 masked write" : (op == 3'd2) ? "R3 single write" :
               (op == 3'd5) ? "R6 flag load" : "R7 no-write opcode";
        check64(ctag, {32'b0, cr_q}, {32'b0, cr_ref});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        cr_ref = '0;
        rst = 1; op_valid = 0; op_code = 0; fld_mask = 0; fld_idx = 0; src_data = 0;
        {flag_ov, flag_ov32, flag_ca, flag_ca32} = 4'h0;
        step(1, 0, 3'd0, 8'h00, 3'd0, 64'h0, 4'h0);
        step(1, 0, 3'd0, 8'h00, 3'd0, 64'h0, 4'h0);
        check64("R7 reset state", {32'b0, cr_q}, 64'h0);

        // R1 R2: all fields, then selected fields and empty mask
        step(0, 1, 3'd1, 8'hFF, 3'd0, 64'hDEAD_BEEF_1234_5678, 4'h0);
        check64("R1 field layout", {32'b0, cr_q}, 64'h1234_5678);
        step(0, 1, 3'd1, 8'h81, 3'd0, 64'h0000_0000_A000_000B, 4'h0);
        check64("R1 mask bit per field", {32'b0, cr_q}, 64'hA234_567B);
        step(0, 1, 3'd1, 8'h00, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'h0);
        // R3: multi-hot mask picks field 2; empty mask picks field 7
        step(0, 1, 3'd2, 8'b0011_0100, 3'd0, 64'h0000_0000_00C0_0000, 4'h0);
        check64("R3 lowest field", {32'b0, cr_q}, 64'hA2C4_567B);
        step(0, 1, 3'd2, 8'h00, 3'd0, 64'h0000_0000_0000_000E, 4'h0);
        check64("R3 default field 7", {32'b0, cr_q}, 64'hA2C4_567E);
        // R4 R5
        step(0, 0, 3'd3, 8'b0001_1000, 3'd0, 64'h0, 4'h0);
        step(0, 0, 3'd3, 8'h00, 3'd0, 64'h0, 4'h0);
        step(0, 1, 3'd4, 8'hFF, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'h0);
        // R6 at both ends
        step(0, 1, 3'd5, 8'h00, 3'd0, 64'h0, 4'b1001);
        step(0, 1, 3'd5, 8'h00, 3'd7, 64'h0, 4'b0110);
        // R7: valid low, reserved opcodes, reset wins over write
        step(0, 0, 3'd1, 8'hFF, 3'd0, 64'h0, 4'h0);
        step(0, 1, 3'd6, 8'hFF, 3'd3, 64'h0, 4'hF);
        step(0, 1, 3'd7, 8'hFF, 3'd3, 64'h0, 4'hF);
        step(1, 1, 3'd1, 8'hFF, 3'd0, 64'hFFFF_FFFF, 4'h0);

        // Random stream; empty masks forced about one cycle in eight
        for (int i = 0; i < 2000; i++) begin
            logic [7:0] m = 8'($urandom);
            if (($urandom % 8) == 0) m = 8'h00;
            step(($urandom % 100) == 0, ($urandom % 4) != 0, 3'($urandom), m,
                 3'($urandom), {$urandom, $urandom}, 4'($urandom));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule